// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-transfer core of a small processor. All of its registers hang off one shared internal bus: four general registers, a program counter, an instruction register, a scratch register TEMP, an operand latch Y, a result latch Z, a memory address register and a memory data register. Every clock cycle an external sequencer presents one control word. The word enables a bus source and any set of register loads, and it selects an ALU function. The same word can also start a memory read or write and ask the step to wait for memory to finish.

The ALU is combinational. Its first operand is either Y or the constant 4. Its second operand is the bus. Its result can only be captured in Z. The memory port is asynchronous and uses a completion handshake, so the response can take any number of cycles. A step that asks to wait holds every register load until the completion pulse arrives. Decoding instructions and sequencing control words are left to the unit that drives this block.

Top module: `sbd_datapath`

## Requirements
- R1: After the asynchronous reset, every register is zero, the bus reads zero, and no strobe, stall or error output is active.
- R2: The bus carries the value of the one source whose out_en_i bit is set. The bit order is 0..3 R0..R3, 4 PC, 5 MDR, 6 Z, 7 TEMP, 8 offset. With no bit set, the bus is zero and bus_err_o is low.
- R3: When two or more out_en_i bits are set, bus_err_o is high, the bus is forced to zero, and any register loaded in that step receives zero.
- R4: Each in_en_i bit loads its register from the bus at the rising edge that ends the step, and several registers may load in the same step. The bit order is 0..3 R0..R3, 4 PC, 5 IR, 6 TEMP, 7 Y, 8 Z, 9 MAR, 10 MDR.
- R5: ALU operand A is Y when sel4_i is 0 and the constant 4 when sel4_i is 1. Operand B is the bus. The result enters Z only when its in_en_i bit is set, and Z reaches the bus only when its out_en_i bit is set.
- R6: ALU functions are selected by alu_fn_i: 0000 gives A+B+carry, 0001 gives A-B-carry, 0010 gives A AND B, 0011 gives A OR B, and 1111 gives A XOR B. Every other code passes B through. All results are taken modulo 2^16.
- R7: The offset source drives the bus with IR bits 7..0, sign-extended to 16 bits. ir_o always shows IR.
- R8: A step with rd_i raises mem_rd_o from the following cycle. mem_rd_o stays high until the cycle in which mfc_i is seen, and drops after it. At that edge MDR captures mem_rdata_i. mem_addr_o always shows MAR.
- R9: A step with wr_i raises mem_wr_o from the following cycle and holds it until mfc_i. mem_wdata_o always shows MDR. A read and a write are never outstanding together.
- R10: While wmfc_i is high and mfc_i is low, stall_o is high and no register load takes effect. The step's loads happen once, at the edge where mfc_i is seen.
- R11: The datapath completes correctly for any memory completion delay from 1 to 5 cycles, and a waiting step stalls for exactly that delay.
- R12: Adding R1 to R2 into R3 takes three steps: R1 to Y; R2 on the bus with Add and Z loaded; then Z to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_en_i | input | 9 | Bus source enables |
| in_en_i | input | 11 | Register load enables |
| alu_fn_i | input | 4 | ALU function code |
| sel4_i | input | 1 | Operand A selects constant 4 |
| carry_i | input | 1 | ALU carry / borrow in |
| rd_i | input | 1 | Start memory read |
| wr_i | input | 1 | Start memory write |
| wmfc_i | input | 1 | Hold step until memory completes |
| mem_addr_o | output | 16 | Memory address (MAR) |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 16 | Write data (MDR) |
| mem_rdata_i | input | 16 | Read data |
| mfc_i | input | 1 | Memory function complete |
| bus_o | output | 16 | Internal bus value |
| bus_err_o | output | 1 | Bus source conflict |
| stall_o | output | 1 | Step held waiting on memory |
| ir_o | output | 16 | Instruction register |

## Verification
Register loads are driven by fetch-style sequences in which the PC walks through a randomly filled memory. The memory answers after a random delay of 1 to 5 cycles, so both the stall length and the data captured in MDR are checked at every latency. Random operand pairs run through every ALU code, with random carry and random operand-A selection. Add and subtract with carry set catch mix-ups between carry and borrow, and the unlisted codes catch a wrong default. Directed cases cover:
- a bus with no source against one with two sources;
- a step without the Z load, which must leave Z untouched;
- offsets with bit 7 set and clear, which separate sign extension from zero fill;
- a write followed by an inspection of the memory model.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  // special bus sources, placed after the general registers
  localparam int unsigned SRC_PC   = 0;
  localparam int unsigned SRC_MDR  = 1;
  localparam int unsigned SRC_Z    = 2;
  localparam int unsigned SRC_TEMP = 3;
  localparam int unsigned SRC_OFS  = 4;
  localparam int unsigned N_SPC_SRC = 5;

  // special load targets, placed after the general registers
  localparam int unsigned LD_PC   = 0;
  localparam int unsigned LD_IR   = 1;
  localparam int unsigned LD_TEMP = 2;
  localparam int unsigned LD_Y    = 3;
  localparam int unsigned LD_Z    = 4;
  localparam int unsigned LD_MAR  = 5;
  localparam int unsigned LD_MDR  = 6;
  localparam int unsigned N_SPC_LD = 7;

  typedef enum logic [3:0] {
    FN_ADD = 4'b0000,
    FN_SUB = 4'b0001,
    FN_AND = 4'b0010,
    FN_OR  = 4'b0011,
    FN_XOR = 4'b1111
  } alu_fn_e;
endpackage

// File: rtl/sbd_alu.sv
module sbd_alu import sbd_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] y_i,
  input  logic          sel4_i,
  input  logic [DW-1:0] b_i,
  input  logic [3:0]    fn_i,
  input  logic          carry_i,
  output logic [DW-1:0] res_o
);
  localparam logic [DW-1:0] CONST4 = DW'(4);

  logic [DW-1:0] a_op;
  logic [DW-1:0] cin;

  assign a_op = sel4_i ? CONST4 : y_i;
  assign cin  = {{(DW-1){1'b0}}, carry_i};

  always_comb begin
    unique case (fn_i)
      FN_ADD:  res_o = a_op + b_i + cin;
      FN_SUB:  res_o = a_op - b_i - cin;
      FN_AND:  res_o = a_op & b_i;
      FN_OR:   res_o = a_op | b_i;
      FN_XOR:  res_o = a_op ^ b_i;
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/sbd_bus.sv
module sbd_bus #(
  parameter int unsigned DW = 16,
  parameter int unsigned NS = 9
) (
  input  logic [NS-1:0][DW-1:0] src_i,
  input  logic [NS-1:0]         en_i,
  output logic [DW-1:0]         bus_o,
  output logic                  err_o
);
  logic [DW-1:0] acc;
  logic          seen;
  logic          multi;

  always_comb begin
    acc   = '0;
    seen  = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < int'(NS); i++) begin
      if (en_i[i]) begin
        if (seen) multi = 1'b1;
        seen = 1'b1;
        acc  = acc | src_i[i];
      end
    end
  end

  assign bus_o = multi ? '0 : acc;
  assign err_o = multi;
endmodule

// File: rtl/sbd_regfile.sv
module sbd_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NREG-1:0]         ld_i,
  input  logic [DW-1:0]           d_i,
  output logic [NREG-1:0][DW-1:0] q_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[g] <= '0;
      else if (ld_i[g]) q_o[g] <= d_i;
    end
  end
endmodule

// File: rtl/sbd_mem_if.sv
module sbd_mem_if #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] bus_i,
  input  logic          mar_ld_i,
  input  logic          mdr_ld_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          mfc_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [DW-1:0] mdr_o
);
  logic [DW-1:0] mar_q, mdr_q;
  logic          rd_pend_q, wr_pend_q;
  logic          idle;

  assign idle = !rd_pend_q && !wr_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (mfc_i) begin
      rd_pend_q <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (idle) begin
      // a read wins if both strobes are requested in one step
      rd_pend_q <= rd_i;
      wr_pend_q <= wr_i && !rd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mar_q <= '0;
    else if (mar_ld_i) mar_q <= bus_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mdr_q <= '0;
    else if (rd_pend_q && mfc_i)  mdr_q <= rdata_i;
    else if (mdr_ld_i)            mdr_q <= bus_i;
  end

  assign addr_o  = mar_q;
  assign wdata_o = mdr_q;
  assign rd_o    = rd_pend_q;
  assign wr_o    = wr_pend_q;
  assign mdr_o   = mdr_q;
endmodule

// File: rtl/sbd_datapath.sv
module sbd_datapath import sbd_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREG   = 4,
  parameter int unsigned OFS_W  = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NREG+N_SPC_SRC-1:0]   out_en_i,
  input  logic [NREG+N_SPC_LD-1:0]    in_en_i,
  input  logic [3:0]                  alu_fn_i,
  input  logic                        sel4_i,
  input  logic                        carry_i,
  input  logic                        rd_i,
  input  logic                        wr_i,
  input  logic                        wmfc_i,
  output logic [DATA_W-1:0]           mem_addr_o,
  output logic                        mem_rd_o,
  output logic                        mem_wr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  input  logic                        mfc_i,
  output logic [DATA_W-1:0]           bus_o,
  output logic                        bus_err_o,
  output logic                        stall_o,
  output logic [DATA_W-1:0]           ir_o
);
  localparam int unsigned N_SRC = NREG + N_SPC_SRC;
  localparam int unsigned N_LD  = NREG + N_SPC_LD;

  logic [N_SRC-1:0][DATA_W-1:0] src;
  logic [N_LD-1:0]              ld;
  logic [NREG-1:0][DATA_W-1:0]  gpr;
  logic [DATA_W-1:0]            bus;
  logic [DATA_W-1:0]            pc_q, ir_q, temp_q, y_q, z_q;
  logic [DATA_W-1:0]            alu_res, mdr, ofs_ext;

  // a waiting step commits nothing until memory answers
  assign stall_o = wmfc_i && !mfc_i;
  assign ld      = in_en_i & {N_LD{!stall_o}};

  assign ofs_ext = {{(DATA_W-OFS_W){ir_q[OFS_W-1]}}, ir_q[OFS_W-1:0]};

  for (genvar g = 0; g < NREG; g++) begin : g_gsrc
    assign src[g] = gpr[g];
  end
  assign src[NREG+SRC_PC]   = pc_q;
  assign src[NREG+SRC_MDR]  = mdr;
  assign src[NREG+SRC_Z]    = z_q;
  assign src[NREG+SRC_TEMP] = temp_q;
  assign src[NREG+SRC_OFS]  = ofs_ext;

  sbd_bus #(.DW(DATA_W), .NS(N_SRC)) u_bus (
    .src_i (src),
    .en_i  (out_en_i),
    .bus_o (bus),
    .err_o (bus_err_o)
  );

  sbd_regfile #(.DW(DATA_W), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld[NREG-1:0]),
    .d_i    (bus),
    .q_o    (gpr)
  );

  sbd_alu #(.DW(DATA_W)) u_alu (
    .y_i     (y_q),
    .sel4_i  (sel4_i),
    .b_i     (bus),
    .fn_i    (alu_fn_i),
    .carry_i (carry_i),
    .res_o   (alu_res)
  );

  sbd_mem_if #(.DW(DATA_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_i    (bus),
    .mar_ld_i (ld[NREG+LD_MAR]),
    .mdr_ld_i (ld[NREG+LD_MDR]),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .mfc_i    (mfc_i),
    .rdata_i  (mem_rdata_i),
    .addr_o   (mem_addr_o),
    .wdata_o  (mem_wdata_o),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .mdr_o    (mdr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      ir_q   <= '0;
      temp_q <= '0;
      y_q    <= '0;
      z_q    <= '0;
    end else begin
      if (ld[NREG+LD_PC])   pc_q   <= bus;
      if (ld[NREG+LD_IR])   ir_q   <= bus;
      if (ld[NREG+LD_TEMP]) temp_q <= bus;
      if (ld[NREG+LD_Y])    y_q    <= bus;
      if (ld[NREG+LD_Z])    z_q    <= alu_res;
    end
  end

  assign bus_o = bus;
  assign ir_o  = ir_q;
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned NS = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NS-1:0] out_en_i,
  input logic          wmfc_i,
  input logic          mfc_i,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] bus_o,
  input logic          bus_err_o,
  input logic          stall_o,
  input logic [DW-1:0] pc_i,
  input logic [DW-1:0] mdr_i
);
  a_r3_conflict_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> bus_o == '0);

  a_r2_single_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_en_i) |-> !bus_err_o);

  a_r10_stall_on_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wmfc_i && !mfc_i) |-> stall_o);

  a_r10_no_stall_on_mfc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mfc_i |-> !stall_o);

  a_r10_pc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(pc_i));

  a_r10_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(mem_addr_o));

  a_r8_rd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mfc_i) |=> mem_rd_o);

  a_r8_rd_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && mfc_i) |=> !mem_rd_o);

  a_r8_mdr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && mfc_i) |=> mdr_i == $past(mem_rdata_i));

  a_r9_wr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !mfc_i) |=> mem_wr_o);

  a_r9_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
endmodule

bind sbd_datapath sbd_checker #(.DW(DATA_W), .NS(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_en_i    (out_en_i),
  .wmfc_i      (wmfc_i),
  .mfc_i       (mfc_i),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_rdata_i (mem_rdata_i),
  .mem_addr_o  (mem_addr_o),
  .bus_o       (bus_o),
  .bus_err_o   (bus_err_o),
  .stall_o     (stall_o),
  .pc_i        (pc_q),
  .mdr_i       (mdr)
);

// File: tb/sim_sbd_datapath.sv
module sim_sbd_datapath;
  localparam int S_PC = 4, S_MDR = 5, S_Z = 6, S_TMP = 7, S_OFS = 8;
  localparam int L_PC = 4, L_IR = 5, L_TMP = 6, L_Y = 7, L_Z = 8, L_MAR = 9, L_MDR = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  out_en = '0;
  logic [10:0] in_en = '0;
  logic [3:0]  alu_fn = '0;
  logic        sel4 = 1'b0, carry = 1'b0, rd = 1'b0, wr = 1'b0, wmfc = 1'b0;
  logic [15:0] mem_addr, mem_wdata, bus, ir;
  logic [15:0] mem_rdata = '0;
  logic        mfc = 1'b0;
  logic        mem_rd, mem_wr, bus_err, stall;

  logic [15:0] mem [256];
  int          checks = 0, fails = 0;
  logic [15:0] last_bus;
  logic        last_err, last_rd;
  int          last_stalls;
  logic [15:0] pc_m = '0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sbd_datapath u0 (
    .clk_i(clk), .rst_ni(rst_n), .out_en_i(out_en), .in_en_i(in_en),
    .alu_fn_i(alu_fn), .sel4_i(sel4), .carry_i(carry), .rd_i(rd), .wr_i(wr),
    .wmfc_i(wmfc), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mfc_i(mfc),
    .bus_o(bus), .bus_err_o(bus_err), .stall_o(stall), .ir_o(ir)
  );

  // memory model: completes each request 1..5 cycles after seeing its strobe
  initial begin
    int cnt = 0;
    bit busy = 1'b0;
    forever begin
      @(posedge clk); #2;
      if (mfc) begin
        mfc = 1'b0; busy = 1'b0;
      end else if (busy) begin
        cnt--;
        if (cnt == 0) begin
          if (mem_rd) mem_rdata = mem[mem_addr[9:2]];
          else        mem[mem_addr[9:2]] = mem_wdata;
          mfc = 1'b1;
        end
      end else if (mem_rd || mem_wr) begin
        busy = 1'b1;
        cnt = int'($urandom_range(5, 1));
      end
    end
  end

  function automatic logic [15:0] alu_ref(logic [15:0] y, logic s4, logic [15:0] b,
                                          logic [3:0] fn, logic ci);
    logic [15:0] a = s4 ? 16'd4 : y;
    case (fn)
      4'b0000: return a + b + 16'(ci);
      4'b0001: return a - b - 16'(ci);
      4'b0010: return a & b;
      4'b0011: return a | b;
      4'b1111: return a ^ b;
      default: return b;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input logic [8:0] oe, input logic [10:0] ie,
                      input logic [3:0] fn = 4'h0, input logic s4 = 1'b0,
                      input logic ci = 1'b0, input logic r = 1'b0,
                      input logic w = 1'b0, input logic wm = 1'b0);
    bit stl;
    out_en = oe; in_en = ie; alu_fn = fn; sel4 = s4; carry = ci;
    rd = r; wr = w; wmfc = wm;
    #1;
    last_bus = bus; last_err = bus_err; last_rd = mem_rd;
    last_stalls = 0;
    forever begin
      stl = stall;
      @(posedge clk); @(negedge clk);
      if (!stl) break;
      last_stalls++;
    end
    out_en = '0; in_en = '0; alu_fn = '0; sel4 = 1'b0; carry = 1'b0;
    rd = 1'b0; wr = 1'b0; wmfc = 1'b0;
  endtask

  task automatic peek(input int s, output logic [15:0] v);
    step(9'(1) << s, '0);
    v = last_bus;
  endtask

  // fetch-style load of mem[PC] into a register; PC advances by 4
  task automatic fetch(input int ldb, output logic [15:0] v);
    v = mem[pc_m[9:2]];
    step(9'(1) << S_PC, (11'(1) << L_MAR) | (11'(1) << L_Z), 4'h0, 1'b1, 1'b0, 1'b1);
    step(9'(1) << S_Z, 11'(1) << L_PC, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    checks++;
    if (!last_rd) begin fails++; $display("FAIL R8 got=%b exp=1 (read strobe)", last_rd); end
    checks++;
    if (last_stalls < 1 || last_stalls > 5) begin
      fails++; $display("FAIL R11 got=%0d exp=1..5 (stall cycles)", last_stalls);
    end
    step(9'(1) << S_MDR, 11'(1) << ldb);
    pc_m = pc_m + 16'd4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b, v, zold;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 bus", bus, 16'h0);
    chk("R1 strobes", {14'h0, mem_rd, mem_wr}, 16'h0);
    chk("R1 stall/err", {14'h0, stall, bus_err}, 16'h0);
    chk("R1 addr", mem_addr, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    peek(S_PC, v); chk("R1 pc", v, 16'h0);
    peek(0, v);    chk("R1 r0", v, 16'h0);

    // R2: no source
    step('0, '0);
    chk("R2 empty bus", last_bus, 16'h0);
    chk("R2 empty err", {15'h0, last_err}, 16'h0);

    // R8, R4: fetched words land in registers
    fetch(1, a); peek(1, v); chk("R8 r1 load", v, a);
    fetch(2, b); peek(2, v); chk("R8 r2 load", v, b);
    peek(S_PC, v); chk("R10 pc after waits", v, 16'd8);

    // R12: three-step add
    step(9'(1) << 1, 11'(1) << L_Y);
    step(9'(1) << 2, 11'(1) << L_Z, 4'b0000);
    step(9'(1) << S_Z, 11'(1) << 3);
    peek(3, v); chk("R12 add", v, a + b);

    // R4: one bus value into two registers
    step(9'(1) << 1, (11'(1) << 0) | (11'(1) << L_TMP));
    peek(0, v); chk("R4 r0", v, a);
    peek(S_TMP, v); chk("R4 temp", v, a);

    // R3: conflict forces zero and loads zero
    step((9'(1) << 1) | (9'(1) << 2), 11'(1) << 0);
    chk("R3 err", {15'h0, last_err}, 16'h1);
    chk("R3 bus", last_bus, 16'h0);
    peek(0, v); chk("R3 r0 zero", v, 16'h0);

    // R5: Z untouched without its load enable
    peek(S_Z, zold);
    step(9'(1) << 2, '0, 4'b0001, 1'b1);
    peek(S_Z, v); chk("R5 z hold", v, zold);

    // R6, R5, R11: random operations with random latency fetches
    for (int it = 0; it < 40; it++) begin
      logic [3:0] fn;
      logic s4, ci;
      int sel = int'($urandom_range(7, 0));
      fn = (sel == 0) ? 4'b0000 : (sel == 1) ? 4'b0001 : (sel == 2) ? 4'b0010 :
           (sel == 3) ? 4'b0011 : (sel == 4) ? 4'b1111 : 4'($urandom_range(14, 4));
      s4 = 1'($urandom); ci = 1'($urandom);
      fetch(1, a); fetch(2, b);
      step(9'(1) << 1, 11'(1) << L_Y);
      step(9'(1) << 2, 11'(1) << L_Z, fn, s4, ci);
      step(9'(1) << S_Z, 11'(1) << 3);
      peek(3, v); chk("R6 alu", v, alu_ref(a, s4, b, fn, ci));
    end

    // R7: offset sign extension
    mem[pc_m[9:2]] = 16'h3A85;
    fetch(L_IR, v);
    chk("R7 ir", ir, 16'h3A85);
    peek(S_OFS, v); chk("R7 neg offset", v, 16'hFF85);
    mem[pc_m[9:2]] = 16'h1234;
    fetch(L_IR, v);
    peek(S_OFS, v); chk("R7 pos offset", v, 16'h0034);

    // R9: write MDR to the address in MAR
    fetch(1, a); fetch(2, b);
    step(9'(1) << 1, 11'(1) << L_MAR);
    step(9'(1) << 2, 11'(1) << L_MDR);
    chk("R9 wdata", mem_wdata, b);
    step('0, '0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 wr strobe", {15'h0, mem_wr}, 16'h1);
    step('0, '0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 stored", mem[a[9:2]], b);
    chk("R9 wr drop", {15'h0, mem_wr}, 16'h0);
    chk("R8 addr is mar", mem_addr, a);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule